// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block sits between the software-visible command register of an I2C master and the bit-level bus engine that drives SCL and SDA. A write supplies a seven-bit command word and the direction bit of the slave address. The block looks the pair up in a table that depends on the current mode (Idle, Transmit or Receive). For an accepted command it plays a short list of micro-operations to the engine, one at a time: start or repeated start, an optional high-speed master code, the address byte, one or N data bytes, and stop.

The engine takes each operation over a request/done handshake. With its done pulse it reports whether the slave refused the byte and whether arbitration was lost. The block keeps an 8-bit status word that software can read. It pulses an interrupt when a sequence ends, whether normally or through an error. It pulses an illegal flag for encodings that the table forbids. Encodings that the table does not list are silently ignored.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset the mode is Idle (mode code 0; Transmit is 1, Receive is 2), no operation is requested, and the status word is 0x20. Status bit positions: 0 busy, 1 error, 2 address refused, 3 data refused, 4 arbitration lost, 5 idle, 6 bus busy, 7 clock timeout.
- R2: Command bits are 0 run, 1 start, 2 stop, 3 ack, 4 high speed, 5 quick, 6 burst. Operation codes are 1 start, 2 repeated start, 3 address, 4 transmit byte, 5 receive byte, 6 stop, 7 master code. In Idle, with direction 0, start=1 and run=1 issues start, address and one transmit byte, then enters Transmit, or issues stop and stays in Idle if stop=1.
- R3: In Idle, with direction 1, start=1 and run=1 issues start, address and one receive byte. The master acknowledges that byte if ack=1. With stop=1 the block issues stop and stays in Idle; otherwise it enters Receive.
- R4: burst=1 with run=0 moves burst_len_i bytes (at least 1). In a receive burst every byte is acknowledged except the last, which takes the ack bit.
- R5: A quick command is quick, start, stop and run set with ack=0, from Idle, with either direction. It issues start, address and stop, moves no data, and ends in Idle.
- R6: In Transmit, run alone sends one byte and stays there. Stop alone issues stop and goes to Idle. Run with stop does both. Start with run issues a repeated start, and the direction bit picks the next mode.
- R7: In Receive, run alone receives one byte, acknowledged when ack=1. Run with stop receives a NACKed byte, then stop, then Idle. Start with run issues a repeated start as in R6.
- R8: A receive with ack=1 and stop=1 (start=1 in Idle or Transmit; run or burst without start in Receive) is illegal. The block pulses illegal_o for one cycle, issues no operation and keeps its mode.
- R9: Any encoding not covered by R2 to R8 or R10 issues no operation, raises no flag and keeps the mode.
- R10: From Idle, direction 0, high speed with start and run (or with burst alone) issues the master code, a repeated start, the address and the data byte(s), then enters Transmit. The refusal of the master code is not an error. eng_hs_o stays high until the next stop.
- R11: A refused address or transmitted data byte sets error and the matching refusal flag, skips the remaining bytes, issues stop and returns to Idle.
- R12: Lost arbitration sets error and the arbitration flag, ends the sequence without stop and returns to Idle.
- R13: A status read clears the two refusal flags on the next cycle. Error and arbitration flags clear when the next command is accepted. Status bits 7 and 6 mirror clk_to_i and bus_busy_i.
- R14: Busy reads 1 from the cycle after an accepted write until the sequence ends, and writes during busy are ignored. irq_o pulses for exactly one cycle when a sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_bits_i | input | 7 | Command word |
| addr_rd_i | input | 1 | Slave address direction bit, 1 = receive |
| burst_len_i | input | LEN_W | Byte count for burst commands |
| stat_rd_i | input | 1 | Status read strobe |
| bus_busy_i | input | 1 | Bus occupied indication from the line monitor |
| clk_to_i | input | 1 | Clock-low timeout indication |
| status_o | output | 8 | Status word |
| mode_o | output | 2 | Current mode |
| irq_o | output | 1 | End-of-sequence pulse |
| illegal_o | output | 1 | Illegal-command pulse |
| eng_req_o | output | 1 | Operation request to the bus engine |
| eng_op_o | output | 3 | Operation code |
| eng_rx_ack_o | output | 1 | Master acknowledges the byte being received |
| eng_hs_o | output | 1 | High-speed phase active |
| eng_done_i | input | 1 | Engine finished the current operation |
| eng_nack_i | input | 1 | Slave refused the byte, valid with done |
| eng_arb_i | input | 1 | Arbitration lost, valid with done |

## Verification
Busy and the first engine request appear one cycle after the write edge, and illegal_o pulses in that same cycle. Mode, irq_o and the error flags all settle in the cycle after the final engine done. A status read takes effect one cycle after its strobe. The bench drives every strobe on the falling edge and samples on falling edges only: one cycle after a write for busy and illegal, and one cycle after busy falls for mode, status and the operation log its engine model builds. The model answers each request two cycles after it appears, so any operation order the bench expects shows up as a concrete sequence of codes.

// File: rtl/i2c_seq_pkg.sv
// Shared types for the I2C master command sequencer.
// Assumes: command word bit positions below are fixed by software.
package i2c_seq_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_TX   = 2'd1,
        MODE_RX   = 2'd2
    } seq_mode_e;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_START  = 3'd1,
        OP_RSTART = 3'd2,
        OP_ADDR   = 3'd3,
        OP_TX     = 3'd4,
        OP_RX     = 3'd5,
        OP_STOP   = 3'd6,
        OP_HSCODE = 3'd7
    } bus_op_e;

    localparam int CB_RUN   = 0;
    localparam int CB_START = 1;
    localparam int CB_STOP  = 2;
    localparam int CB_ACK   = 3;
    localparam int CB_HS    = 4;
    localparam int CB_QUICK = 5;
    localparam int CB_BURST = 6;
    localparam int CMD_W    = 7;

    typedef struct packed {
        logic      accept;
        logic      illegal;
        logic      hs;
        logic      start;
        logic      rstart;
        logic      data;
        logic      burst;
        logic      rx;
        logic      ack_last;
        logic      stop;
        seq_mode_e next_mode;
    } seq_plan_t;

endpackage

// File: rtl/i2c_seq_decode.sv
// Command table: turns mode, direction bit and command word into a plan.
// Assumes: purely combinational; the caller gates the plan with busy.
module i2c_seq_decode
    import i2c_seq_pkg::*;
(
    input  seq_mode_e          mode_i,
    input  logic               rs_i,
    input  logic [CMD_W-1:0]   cmd_i,
    output seq_plan_t          plan_o
);

    logic b, q, h, a, p, s, r;
    logic start_path, quick_path, hs_path, cont_path, cont_rx;

    // Split the command word and classify it into one table group.
    always_comb begin
        b = cmd_i[CB_BURST];
        q = cmd_i[CB_QUICK];
        h = cmd_i[CB_HS];
        a = cmd_i[CB_ACK];
        p = cmd_i[CB_STOP];
        s = cmd_i[CB_START];
        r = cmd_i[CB_RUN];
        start_path = s && !q && !h && (b ? !r : r);
        quick_path = q && s && r && p && !b && !h && !a && (mode_i == MODE_IDLE);
        hs_path    = h && !q && !a && !p && !rs_i && (mode_i == MODE_IDLE)
                     && ((s && r && !b) || (!s && !r && b));
        cont_path  = !s && !q && !h && (mode_i != MODE_IDLE);
        cont_rx    = (mode_i == MODE_RX);
    end

    // Build the operation plan for the selected group.
    always_comb begin
        plan_o = '0;
        plan_o.next_mode = mode_i;
        if (start_path) begin
            if (rs_i && a && p) begin
                plan_o.illegal = 1'b1;
            end else begin
                plan_o.accept    = 1'b1;
                plan_o.start     = 1'b1;
                plan_o.rstart    = (mode_i != MODE_IDLE);
                plan_o.data      = 1'b1;
                plan_o.burst     = b;
                plan_o.rx        = rs_i;
                plan_o.ack_last  = rs_i && a;
                plan_o.stop      = p;
                plan_o.next_mode = p ? MODE_IDLE : (rs_i ? MODE_RX : MODE_TX);
            end
        end else if (quick_path) begin
            plan_o.accept    = 1'b1;
            plan_o.start     = 1'b1;
            plan_o.stop      = 1'b1;
            plan_o.next_mode = MODE_IDLE;
        end else if (hs_path) begin
            plan_o.accept    = 1'b1;
            plan_o.hs        = 1'b1;
            plan_o.start     = 1'b1;
            plan_o.rstart    = 1'b1;
            plan_o.data      = 1'b1;
            plan_o.burst     = b;
            plan_o.next_mode = MODE_TX;
        end else if (cont_path) begin
            if (b != r) begin
                if (cont_rx && a && p) begin
                    plan_o.illegal = 1'b1;
                end else begin
                    plan_o.accept    = 1'b1;
                    plan_o.data      = 1'b1;
                    plan_o.burst     = b;
                    plan_o.rx        = cont_rx;
                    plan_o.ack_last  = cont_rx && a;
                    plan_o.stop      = p;
                    plan_o.next_mode = p ? MODE_IDLE : mode_i;
                end
            end else if (!b && !r && p) begin
                plan_o.accept    = 1'b1;
                plan_o.stop      = 1'b1;
                plan_o.next_mode = MODE_IDLE;
            end
        end
    end

endmodule

// File: rtl/i2c_seq_ctrl.sv
// Sequencer: plays the planned operations to the bus engine one by one,
// handles refusal and arbitration aborts, and owns the mode register.
// Assumes: the engine asserts done only while a request is pending.
module i2c_seq_ctrl
    import i2c_seq_pkg::*;
#(
    parameter int LEN_W = 8
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic             hs_i,
    input  logic             start_i,
    input  logic             rstart_i,
    input  logic             data_i,
    input  logic             burst_i,
    input  logic             rx_i,
    input  logic             ack_last_i,
    input  logic             stop_i,
    input  seq_mode_e        next_mode_i,
    input  logic [LEN_W-1:0] burst_len_i,
    input  logic             eng_done_i,
    input  logic             eng_nack_i,
    input  logic             eng_arb_i,
    output logic             busy_o,
    output seq_mode_e        mode_o,
    output logic             eng_req_o,
    output bus_op_e          eng_op_o,
    output logic             eng_rx_ack_o,
    output logic             eng_hs_o,
    output logic             end_o,
    output logic             adr_nack_o,
    output logic             dat_nack_o,
    output logic             arb_o
);

    typedef enum logic [2:0] {
        ST_IDLE, ST_HS, ST_START, ST_ADDR, ST_DATA, ST_STOP
    } seq_state_e;

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    seq_state_e       st;
    seq_mode_e        next_q;
    logic [LEN_W-1:0] cnt;
    logic             rstart_q, data_q, rx_q, ack_last_q, stop_q, hs_q;
    logic             last_byte, step;

    assign last_byte = (cnt == ONE);
    assign step      = eng_req_o && eng_done_i;

    // Decode the current state into the engine request.
    always_comb begin
        eng_req_o    = (st != ST_IDLE);
        eng_rx_ack_o = 1'b0;
        case (st)
            ST_HS:    eng_op_o = OP_HSCODE;
            ST_START: eng_op_o = rstart_q ? OP_RSTART : OP_START;
            ST_ADDR:  eng_op_o = OP_ADDR;
            ST_DATA: begin
                eng_op_o     = rx_q ? OP_RX : OP_TX;
                eng_rx_ack_o = rx_q && (last_byte ? ack_last_q : 1'b1);
            end
            ST_STOP:  eng_op_o = OP_STOP;
            default:  eng_op_o = OP_NONE;
        endcase
    end

    // Report abort causes and the end of a sequence in the finishing cycle.
    always_comb begin
        arb_o      = step && eng_arb_i;
        adr_nack_o = step && !eng_arb_i && (st == ST_ADDR) && eng_nack_i;
        dat_nack_o = step && !eng_arb_i && (st == ST_DATA) && !rx_q && eng_nack_i;
        end_o      = step && (eng_arb_i
                     || (st == ST_STOP)
                     || ((st == ST_ADDR) && !eng_nack_i && !data_q && !stop_q)
                     || ((st == ST_DATA) && last_byte && !dat_nack_o && !stop_q));
    end

    assign busy_o   = (st != ST_IDLE);
    assign eng_hs_o = hs_q;

    // Step the sequence state, byte counter and mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            mode_o     <= MODE_IDLE;
            next_q     <= MODE_IDLE;
            cnt        <= '0;
            rstart_q   <= 1'b0;
            data_q     <= 1'b0;
            rx_q       <= 1'b0;
            ack_last_q <= 1'b0;
            stop_q     <= 1'b0;
            hs_q       <= 1'b0;
        end else if (st == ST_IDLE) begin
            if (accept_i) begin
                rstart_q   <= rstart_i;
                data_q     <= data_i;
                rx_q       <= rx_i;
                ack_last_q <= ack_last_i;
                stop_q     <= stop_i;
                next_q     <= next_mode_i;
                cnt        <= (burst_i && (burst_len_i != '0)) ? burst_len_i : ONE;
                if (hs_i) hs_q <= 1'b1;
                st <= hs_i ? ST_HS : start_i ? ST_START : data_i ? ST_DATA : ST_STOP;
            end
        end else if (eng_done_i) begin
            if (eng_arb_i) begin
                st     <= ST_IDLE;
                mode_o <= MODE_IDLE;
                hs_q   <= 1'b0;
            end else begin
                case (st)
                    ST_HS:    st <= ST_START;
                    ST_START: st <= ST_ADDR;
                    ST_ADDR: begin
                        if (eng_nack_i) begin
                            st     <= ST_STOP;
                            next_q <= MODE_IDLE;
                        end else if (data_q) begin
                            st <= ST_DATA;
                        end else if (stop_q) begin
                            st <= ST_STOP;
                        end else begin
                            st     <= ST_IDLE;
                            mode_o <= next_q;
                        end
                    end
                    ST_DATA: begin
                        if (dat_nack_o) begin
                            st     <= ST_STOP;
                            next_q <= MODE_IDLE;
                        end else if (last_byte) begin
                            if (stop_q) begin
                                st <= ST_STOP;
                            end else begin
                                st     <= ST_IDLE;
                                mode_o <= next_q;
                            end
                        end else begin
                            cnt <= cnt - ONE;
                        end
                    end
                    ST_STOP: begin
                        st     <= ST_IDLE;
                        mode_o <= next_q;
                        hs_q   <= 1'b0;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // R2: an operation stays presented until the engine completes it.
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req_o && !eng_done_i) |=> (eng_req_o && $stable(eng_op_o)));

    // R11: a completed stop always leaves the block idle in Idle mode.
    p_stop_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (eng_op_o == OP_STOP)) |=> (!busy_o && (mode_o == MODE_IDLE)));

    // R12: lost arbitration ends the sequence with no further request.
    p_arb_nostop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (step && eng_arb_i) |=> (!eng_req_o && (mode_o == MODE_IDLE)));

endmodule

// File: rtl/i2c_seq_status.sv
// Status word: sticky error flags, read-to-clear refusal flags, live bits.
// Assumes: accept and abort events never fall in the same cycle.
module i2c_seq_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept_i,
    input  logic       rd_i,
    input  logic       adr_nack_i,
    input  logic       dat_nack_i,
    input  logic       arb_i,
    input  logic       busy_i,
    input  logic       mode_idle_i,
    input  logic       bus_busy_i,
    input  logic       clk_to_i,
    output logic [7:0] status_o
);

    logic err_q, arb_q, adr_q, dat_q;

    // Update the flags; a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            arb_q <= 1'b0;
            adr_q <= 1'b0;
            dat_q <= 1'b0;
        end else begin
            if (accept_i) begin
                err_q <= 1'b0;
                arb_q <= 1'b0;
            end
            if (rd_i) begin
                adr_q <= 1'b0;
                dat_q <= 1'b0;
            end
            if (adr_nack_i) begin
                adr_q <= 1'b1;
                err_q <= 1'b1;
            end
            if (dat_nack_i) begin
                dat_q <= 1'b1;
                err_q <= 1'b1;
            end
            if (arb_i) begin
                arb_q <= 1'b1;
                err_q <= 1'b1;
            end
        end
    end

    // Assemble the status word.
    assign status_o = {clk_to_i, bus_busy_i, (!busy_i && mode_idle_i),
                       arb_q, dat_q, adr_q, err_q, busy_i};

    // R13: a read with no new refusal leaves both refusal flags clear.
    p_read_clears_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !adr_nack_i && !dat_nack_i) |=> (status_o[3:2] == 2'b00));

endmodule

// File: rtl/i2c_cmd_seq.sv
// Top of the I2C master command sequencer: table decode, sequencer and
// status word, plus the registered illegal and interrupt pulses.
// Assumes: cmd_wr_i and stat_rd_i are single-cycle strobes.
module i2c_cmd_seq
    import i2c_seq_pkg::*;
#(
    parameter int LEN_W = 8
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr_i,
    input  logic [6:0]       cmd_bits_i,
    input  logic             addr_rd_i,
    input  logic [LEN_W-1:0] burst_len_i,
    input  logic             stat_rd_i,
    input  logic             bus_busy_i,
    input  logic             clk_to_i,
    output logic [7:0]       status_o,
    output logic [1:0]       mode_o,
    output logic             irq_o,
    output logic             illegal_o,
    output logic             eng_req_o,
    output logic [2:0]       eng_op_o,
    output logic             eng_rx_ack_o,
    output logic             eng_hs_o,
    input  logic             eng_done_i,
    input  logic             eng_nack_i,
    input  logic             eng_arb_i
);

    seq_plan_t plan;
    seq_mode_e mode;
    bus_op_e   op;
    logic      busy, accept, ev_end, ev_adr, ev_dat, ev_arb;

    i2c_seq_decode u_decode (
        .mode_i (mode),
        .rs_i   (addr_rd_i),
        .cmd_i  (cmd_bits_i),
        .plan_o (plan)
    );

    assign accept = cmd_wr_i && !busy && plan.accept;

    i2c_seq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept_i     (accept),
        .hs_i         (plan.hs),
        .start_i      (plan.start),
        .rstart_i     (plan.rstart),
        .data_i       (plan.data),
        .burst_i      (plan.burst),
        .rx_i         (plan.rx),
        .ack_last_i   (plan.ack_last),
        .stop_i       (plan.stop),
        .next_mode_i  (plan.next_mode),
        .burst_len_i  (burst_len_i),
        .eng_done_i   (eng_done_i),
        .eng_nack_i   (eng_nack_i),
        .eng_arb_i    (eng_arb_i),
        .busy_o       (busy),
        .mode_o       (mode),
        .eng_req_o    (eng_req_o),
        .eng_op_o     (op),
        .eng_rx_ack_o (eng_rx_ack_o),
        .eng_hs_o     (eng_hs_o),
        .end_o        (ev_end),
        .adr_nack_o   (ev_adr),
        .dat_nack_o   (ev_dat),
        .arb_o        (ev_arb)
    );

    i2c_seq_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .rd_i        (stat_rd_i),
        .adr_nack_i  (ev_adr),
        .dat_nack_i  (ev_dat),
        .arb_i       (ev_arb),
        .busy_i      (busy),
        .mode_idle_i (mode == MODE_IDLE),
        .bus_busy_i  (bus_busy_i),
        .clk_to_i    (clk_to_i),
        .status_o    (status_o)
    );

    assign mode_o   = mode;
    assign eng_op_o = op;

    // Register the illegal-command and end-of-sequence pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            illegal_o <= 1'b0;
            irq_o     <= 1'b0;
        end else begin
            illegal_o <= cmd_wr_i && !busy && plan.illegal;
            irq_o     <= ev_end;
        end
    end

    // R14: a write that lands while busy raises no illegal pulse.
    p_busy_ignore_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr_i) |=> !illegal_o);

    // R14: the sequence end and the interrupt pulse coincide.
    p_irq_at_end_r14: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq_o);

    // R8: an illegal command starts no bus activity.
    p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!busy && !eng_req_o));

endmodule

// File: tb/i2c_cmd_seq_tb_top.sv
// Bench: a chained command table walked by one loop, then directed tests
// for reset, aborts, status reads and writes during busy.
module i2c_cmd_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [6:0] cmd_bits = '0;
    logic       addr_rd = 1'b0;
    logic [7:0] burst_len = '0;
    logic       stat_rd = 1'b0;
    logic       bus_busy = 1'b0;
    logic       clk_to = 1'b0;
    logic [7:0] status;
    logic [1:0] mode;
    logic       irq, illegal, eng_req, eng_rx_ack, eng_hs;
    logic [2:0] eng_op;
    logic       eng_done, eng_nack, eng_arb;

    always #2 clk = ~clk;

    i2c_cmd_seq #(.LEN_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr_i(cmd_wr), .cmd_bits_i(cmd_bits),
        .addr_rd_i(addr_rd), .burst_len_i(burst_len), .stat_rd_i(stat_rd),
        .bus_busy_i(bus_busy), .clk_to_i(clk_to), .status_o(status),
        .mode_o(mode), .irq_o(irq), .illegal_o(illegal), .eng_req_o(eng_req),
        .eng_op_o(eng_op), .eng_rx_ack_o(eng_rx_ack), .eng_hs_o(eng_hs),
        .eng_done_i(eng_done), .eng_nack_i(eng_nack), .eng_arb_i(eng_arb)
    );

    // Engine model and logger: answers each request two cycles later.
    logic [2:0]  nack_op = 3'd0;
    logic [2:0]  arb_op = 3'd0;
    logic        log_clr = 1'b0;
    logic [1:0]  wcnt;
    logic [31:0] log_ops;
    int          log_n, irq_cnt;
    logic        ill_seen;

    always @(posedge clk) begin
        if (!rst_n || log_clr) begin
            log_ops  <= '0;
            log_n    <= 0;
            irq_cnt  <= 0;
            ill_seen <= 1'b0;
        end else begin
            if (irq) irq_cnt <= irq_cnt + 1;
            if (illegal) ill_seen <= 1'b1;
            if (eng_req && !eng_done && wcnt == 2'd1) begin
                log_ops <= log_ops | (32'({((eng_op == 3'd5) ? eng_rx_ack : eng_hs), eng_op}) << (4 * log_n));
                log_n   <= log_n + 1;
            end
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            eng_done <= 1'b0; eng_nack <= 1'b0; eng_arb <= 1'b0; wcnt <= '0;
        end else begin
            eng_done <= 1'b0; eng_nack <= 1'b0; eng_arb <= 1'b0;
            if (eng_req && !eng_done) begin
                if (wcnt == 2'd1) begin
                    eng_done <= 1'b1;
                    eng_nack <= (eng_op == nack_op) || (eng_op == 3'd7);
                    eng_arb  <= (eng_op == arb_op);
                    wcnt     <= '0;
                end else begin
                    wcnt <= wcnt + 2'd1;
                end
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    logic busy_after;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input logic rs, input logic [6:0] c, input logic [7:0] bl);
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
        addr_rd = rs; cmd_bits = c; burst_len = bl; cmd_wr = 1'b1;
        @(negedge clk); cmd_wr = 1'b0;
        busy_after = status[0];
        for (int g = 0; g < 200 && status[0]; g++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic read_status();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    // Rows: {dir, cmd, blen, ops (first op in low nibble), mode, illegal}.
    // Op nibble: bit3 = rx ack for receive ops, else high-speed flag.
    localparam logic [46:0] VEC [0:20] = '{
        {1'b0, 7'h03, 4'd0, 32'h00000431, 2'd1, 1'b0},
        {1'b0, 7'h01, 4'd0, 32'h00000004, 2'd1, 1'b0},
        {1'b0, 7'h40, 4'd3, 32'h00000444, 2'd1, 1'b0},
        {1'b1, 7'h0B, 4'd0, 32'h00000D32, 2'd2, 1'b0},
        {1'b0, 7'h09, 4'd0, 32'h0000000D, 2'd2, 1'b0},
        {1'b0, 7'h40, 4'd3, 32'h000005DD, 2'd2, 1'b0},
        {1'b0, 7'h0D, 4'd0, 32'h00000000, 2'd2, 1'b1},
        {1'b0, 7'h05, 4'd0, 32'h00000065, 2'd0, 1'b0},
        {1'b1, 7'h07, 4'd0, 32'h00006531, 2'd0, 1'b0},
        {1'b1, 7'h0F, 4'd0, 32'h00000000, 2'd0, 1'b1},
        {1'b0, 7'h27, 4'd0, 32'h00000631, 2'd0, 1'b0},
        {1'b0, 7'h01, 4'd0, 32'h00000000, 2'd0, 1'b0},
        {1'b0, 7'h46, 4'd2, 32'h00064431, 2'd0, 1'b0},
        {1'b1, 7'h4A, 4'd2, 32'h0000DD31, 2'd2, 1'b0},
        {1'b0, 7'h03, 4'd0, 32'h00000432, 2'd1, 1'b0},
        {1'b0, 7'h04, 4'd0, 32'h00000006, 2'd0, 1'b0},
        {1'b0, 7'h13, 4'd0, 32'h0000CBAF, 2'd1, 1'b0},
        {1'b0, 7'h05, 4'd0, 32'h000000EC, 2'd0, 1'b0},
        {1'b1, 7'h27, 4'd0, 32'h00000631, 2'd0, 1'b0},
        {1'b0, 7'h50, 4'd2, 32'h000CCBAF, 2'd1, 1'b0},
        {1'b0, 7'h04, 4'd0, 32'h0000000E, 2'd0, 1'b0}
    };

    function automatic string row_tag(input int i);
        case (i)
            0:  return "R2 idle tx";
            1, 3, 15, 17, 20: return "R6 transmit mode";
            2, 5, 12, 13: return "R4 burst";
            4, 7, 14: return "R7 receive mode";
            6, 9: return "R8 illegal";
            8:  return "R3 idle rx";
            10, 18: return "R5 quick";
            11: return "R9 nop";
            default: return "R10 high speed";
        endcase
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state while reset is held
        check("R1 reset status", 32'(status), 32'h20);
        check("R1 reset mode", 32'(mode), 32'd0);
        check("R1 reset request", 32'(eng_req), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 21; i++) begin
            do_cmd(VEC[i][46], VEC[i][45:39], 8'(VEC[i][38:35]));
            check({row_tag(i), " ops"}, log_ops, VEC[i][34:3]);
            check({row_tag(i), " mode"}, 32'(mode), 32'(VEC[i][2:1]));
            check({row_tag(i), " illegal flag"}, 32'(ill_seen), 32'(VEC[i][0]));
            check({row_tag(i), " R14 irq count"}, irq_cnt, (VEC[i][34:3] != 0) ? 1 : 0);
        end

        // R11: address refused -> stop, error and address flag
        nack_op = 3'd3;
        do_cmd(1'b0, 7'h03, 8'd0);
        nack_op = 3'd0;
        check("R11 addr nack ops", log_ops, 32'h631);
        check("R11 addr nack status", 32'(status), 32'h26);
        check("R11 addr nack mode", 32'(mode), 32'd0);
        check("R14 irq on abort", irq_cnt, 1);
        read_status();
        check("R13 read clears refusal", 32'(status), 32'h22);

        // R11: data refused in a burst -> remaining bytes skipped
        nack_op = 3'd4;
        do_cmd(1'b0, 7'h42, 8'd3);
        nack_op = 3'd0;
        check("R11 data nack ops", log_ops, 32'h6431);
        check("R11 data nack status", 32'(status), 32'h2A);
        read_status();

        // R12: arbitration lost on the address -> no stop
        arb_op = 3'd3;
        do_cmd(1'b0, 7'h03, 8'd0);
        arb_op = 3'd0;
        check("R12 arb ops", log_ops, 32'h31);
        check("R12 arb status", 32'(status), 32'h32);
        check("R12 arb mode", 32'(mode), 32'd0);

        // R13: next accepted command clears error and arbitration flags
        do_cmd(1'b1, 7'h07, 8'd0);
        check("R13 error cleared", 32'(status), 32'h20);
        bus_busy = 1'b1; clk_to = 1'b1;
        @(negedge clk);
        check("R13 live bits", 32'(status[7:6]), 32'h3);
        bus_busy = 1'b0; clk_to = 1'b0;

        // R14: write during busy is ignored
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
        addr_rd = 1'b0; cmd_bits = 7'h03; cmd_wr = 1'b1;
        @(negedge clk);
        check("R14 busy after write", 32'(status[0]), 32'd1);
        cmd_bits = 7'h04;
        @(negedge clk); cmd_wr = 1'b0;
        for (int g = 0; g < 200 && status[0]; g++) @(negedge clk);
        @(negedge clk);
        check("R14 ignored write ops", log_ops, 32'h431);
        check("R14 ignored write mode", 32'(mode), 32'd1);
        check("R14 single irq", irq_cnt, 1);
        do_cmd(1'b0, 7'h04, 8'd0);
        check("R6 final stop mode", 32'(mode), 32'd0);

        summary();
        $finish;
    end

endmodule